// File: doc/BRIEF.md
# Byte-Serial Register Write Decoder

This block sits on a narrow command bus running on the system clock. A bus master sends register writes as short bursts of bytes: a start strobe marks the first byte. Two address bytes and then four data bytes follow on consecutive cycles. The block collects each burst and checks the 16-bit address against up to three programmable base/mask windows. When the address falls inside a window, the block presents the low relative address bits, the 32-bit data word and a one-cycle write enable to the registers behind it.

Bytes that arrive outside a burst are ignored. A new strobe always wins over a burst that is still being collected, so a master can recover from a truncated command by starting a new one. A miss leaves the outputs exactly as they were. The register file behind the block can therefore treat the address and data outputs as held values and act only on the enable.

Top module: `cmdser_top`

## Requirements
- R1: While reset is high and after it is released, `reg_we_o` is 0 and `reg_addr_o` and `reg_data_o` are all zeros until the first accepted command.
- R2: A command is six bytes on consecutive cycles: address bits 7:0 (with `cmd_stb_i` high), address bits 15:8, then data bytes assembled least-significant first into `reg_data_o[7:0]`, `[15:8]`, `[23:16]` and `[31:24]`.
- R3: Window 0 (base 0x0404, mask 0x07FC by default) accepts an address when the address AND mask equals the base AND mask. Bits outside the mask are don't-care.
- R4: On an accepted command `reg_addr_o` equals address bits 1:0.
- R5: `reg_we_o` is high for exactly one cycle. It is set by the same clock edge that samples the sixth byte, so counting the strobe's edge as the first, it is high after the sixth edge and low again after the seventh.
- R6: A command whose address hits no window produces no write enable, and `reg_addr_o` and `reg_data_o` keep their previous values.
- R7: A strobe that arrives while a command is partly collected, including in the sixth-byte slot, discards the partial command and starts a new one with that byte as address bits 7:0.
- R8: Bytes presented with `cmd_stb_i` low while no command is being collected have no effect on any output.
- R9: Windows 1 and 2 decode with the same rule as window 0, using their own base and mask. A window whose mask is zero never matches.
- R10: A strobe in the cycle directly after a command's sixth byte starts the next command, and both commands are accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_byte_i | input | 8 | Command byte, one per cycle |
| cmd_stb_i | input | 1 | High with the first byte of a command |
| reg_addr_o | output | 2 | Relative register address of the last accepted write |
| reg_data_o | output | 32 | Data word of the last accepted write |
| reg_we_o | output | 1 | One-cycle write enable |

## Verification
The strobe byte is sampled on one edge and the five following bytes on the next five edges. All three outputs update on the sixth of those edges. Each check on `reg_we_o`, `reg_addr_o` and `reg_data_o` is therefore made at the falling edge right after the sixth byte is sampled. A second check follows one cycle later to confirm the enable has dropped. Every byte is driven on a falling edge, and the outputs are also checked after the cycles of aborted, idle and missing commands, where no enable may appear. The sweep covers every low 12-bit address with two upper-nibble values, and the expected hit and held outputs come from the window arithmetic in the bench.

// File: rtl/cmdser_pkg.sv
package cmdser_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 32;
    localparam int NUM_BEAT = 6;
    localparam int ADDR_BYT = ADDR_W / BYTE_W;
    localparam int BEAT_IW  = $clog2(NUM_BEAT);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [BEAT_IW-1:0] beat_idx_t;

    typedef struct packed {
        addr_t addr;
        data_t data;
    } cmd_word_t;

    function automatic logic window_hit(input addr_t a, input addr_t base, input addr_t mask);
        return (mask != '0) && ((a & mask) == (base & mask));
    endfunction

endpackage

// File: rtl/cmdser_collect.sv
module cmdser_collect
    import cmdser_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  byte_t     byte_i,
    input  logic      stb_i,
    output logic      last_o,
    output cmd_word_t word_o
);
    localparam beat_idx_t LAST_IDX = beat_idx_t'(NUM_BEAT - 1);

    logic      active_q;
    beat_idx_t idx_q;
    byte_t     beat_q [NUM_BEAT-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            idx_q    <= '0;
        end else if (stb_i) begin
            active_q <= 1'b1;
            idx_q    <= beat_idx_t'(1);
        end else if (active_q) begin
            if (idx_q == LAST_IDX) begin
                active_q <= 1'b0;
                idx_q    <= '0;
            end else begin
                idx_q <= idx_q + beat_idx_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BEAT - 1; i++) beat_q[i] <= '0;
        end else if (stb_i) begin
            beat_q[0] <= byte_i;
        end else if (active_q && idx_q != LAST_IDX) begin
            for (int i = 1; i < NUM_BEAT - 1; i++)
                if (idx_q == beat_idx_t'(i)) beat_q[i] <= byte_i;
        end
    end

    assign last_o = active_q && !stb_i && (idx_q == LAST_IDX);

    always_comb begin
        logic [NUM_BEAT*BYTE_W-1:0] flat;
        for (int i = 0; i < NUM_BEAT - 1; i++)
            flat[i*BYTE_W +: BYTE_W] = beat_q[i];
        flat[(NUM_BEAT-1)*BYTE_W +: BYTE_W] = byte_i;
        word_o.addr = flat[0 +: ADDR_W];
        word_o.data = flat[ADDR_W +: DATA_W];
    end

    // R7: a strobe always restarts collection at the second beat slot
    assert_stb_restarts_R7: assert property (@(posedge clk) disable iff (rst)
        stb_i |=> (active_q && idx_q == beat_idx_t'(1)));

    // R8: an idle bus keeps the collector idle
    assert_idle_stays_R8: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !stb_i) |=> !active_q);

endmodule

// File: rtl/cmdser_match.sv
module cmdser_match
    import cmdser_pkg::*;
#(
    parameter int                    NUM_WIN = 3,
    parameter logic [NUM_WIN*ADDR_W-1:0] BASES = '0,
    parameter logic [NUM_WIN*ADDR_W-1:0] MASKS = '0
) (
    input  addr_t addr_i,
    output logic  hit_o
);
    logic [NUM_WIN-1:0] win_hit;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam addr_t W_BASE = BASES[g*ADDR_W +: ADDR_W];
        localparam addr_t W_MASK = MASKS[g*ADDR_W +: ADDR_W];
        if (W_MASK == '0) begin : g_off
            assign win_hit[g] = 1'b0;
        end else begin : g_on
            assign win_hit[g] = window_hit(addr_i, W_BASE, W_MASK);
        end
    end

    assign hit_o = |win_hit;

endmodule

// File: rtl/cmdser_top.sv
module cmdser_top
    import cmdser_pkg::*;
#(
    parameter logic [15:0] WIN0_BASE = 16'h0404,
    parameter logic [15:0] WIN0_MASK = 16'h07FC,
    parameter logic [15:0] WIN1_BASE = 16'h0000,
    parameter logic [15:0] WIN1_MASK = 16'h0000,
    parameter logic [15:0] WIN2_BASE = 16'h0000,
    parameter logic [15:0] WIN2_MASK = 16'h0000,
    parameter int          REL_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        cmd_byte_i,
    input  logic              cmd_stb_i,
    output logic [REL_W-1:0]  reg_addr_o,
    output logic [31:0]       reg_data_o,
    output logic              reg_we_o
);
    localparam int NUM_WIN = 3;
    localparam logic [NUM_WIN*ADDR_W-1:0] BASES = {WIN2_BASE, WIN1_BASE, WIN0_BASE};
    localparam logic [NUM_WIN*ADDR_W-1:0] MASKS = {WIN2_MASK, WIN1_MASK, WIN0_MASK};

    logic      last_beat;
    cmd_word_t word;
    logic      hit;

    cmdser_collect u_collect (
        .clk    (clk),
        .rst    (rst),
        .byte_i (cmd_byte_i),
        .stb_i  (cmd_stb_i),
        .last_o (last_beat),
        .word_o (word)
    );

    cmdser_match #(
        .NUM_WIN (NUM_WIN),
        .BASES   (BASES),
        .MASKS   (MASKS)
    ) u_match (
        .addr_i (word.addr),
        .hit_o  (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_we_o   <= 1'b0;
            reg_addr_o <= '0;
            reg_data_o <= '0;
        end else begin
            reg_we_o <= last_beat && hit;
            if (last_beat && hit) begin
                reg_addr_o <= word.addr[REL_W-1:0];
                reg_data_o <= word.data;
            end
        end
    end

    // R5: enable never lasts more than one cycle
    assert_we_single_R5: assert property (@(posedge clk) disable iff (rst)
        reg_we_o |=> !reg_we_o);

    // R5: an enable traces back to a strobe six edges earlier
    assert_we_after_stb_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(reg_we_o) |-> $past(cmd_stb_i, 6));

    // R6: data and address move only together with an enable
    assert_hold_on_miss_R6: assert property (@(posedge clk) disable iff (rst)
        (!$stable(reg_data_o) || !$stable(reg_addr_o)) |-> reg_we_o);

endmodule

// File: tb/cmdser_top_tb.sv
`timescale 1ns/1ps
module cmdser_top_tb;

    localparam logic [15:0] B0 = 16'h0404, M0 = 16'h07FC;
    localparam logic [15:0] B1 = 16'h1230, M1 = 16'hFFF0;
    localparam logic [15:0] B2 = 16'h0800, M2 = 16'h0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cmd_byte = '0;
    logic        cmd_stb = 1'b0;
    logic [1:0]  reg_addr;
    logic [31:0] reg_data;
    logic        reg_we;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [1:0]  m_addr = '0;
    logic [31:0] m_data = '0;

    always #5 clk = ~clk;

    cmdser_top #(
        .WIN0_BASE(B0), .WIN0_MASK(M0),
        .WIN1_BASE(B1), .WIN1_MASK(M1),
        .WIN2_BASE(B2), .WIN2_MASK(M2),
        .REL_W(2)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .cmd_byte_i (cmd_byte),
        .cmd_stb_i  (cmd_stb),
        .reg_addr_o (reg_addr),
        .reg_data_o (reg_data),
        .reg_we_o   (reg_we)
    );

    function automatic logic exp_hit(input logic [15:0] a);
        return ((a & M0) == (B0 & M0)) || ((a & M1) == (B1 & M1));
    endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_outs(input logic we_exp, input string tag);
        check(reg_we == we_exp, {tag, " we"}, 64'(reg_we), 64'(we_exp));
        check(reg_addr == m_addr && reg_data == m_data, {tag, " addr/data"},
              {30'd0, reg_addr, reg_data}, {30'd0, m_addr, m_data});
    endtask

    task automatic put(input logic s, input logic [7:0] b);
        cmd_stb  = s;
        cmd_byte = b;
        @(negedge clk);
    endtask

    task automatic idle();
        put(1'b0, 8'hA5);
    endtask

    // sends six bytes; returns at the falling edge where the result is due
    task automatic send(input logic [15:0] a, input logic [31:0] d);
        put(1'b1, a[7:0]);
        put(1'b0, a[15:8]);
        put(1'b0, d[7:0]);
        put(1'b0, d[15:8]);
        put(1'b0, d[23:16]);
        put(1'b0, d[31:24]);
        cmd_stb = 1'b0;
        if (exp_hit(a)) begin
            m_addr = a[1:0];
            m_data = d;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        check_outs(1'b0, "R1 in reset");
        repeat (2) @(negedge clk);
        rst = 1'b0;
        idle();
        check_outs(1'b0, "R1 after reset");

        // R2 R4 R5: byte order, relative address, one-cycle enable
        send(16'h0406, 32'hDDCCBBAA);
        check_outs(1'b1, "R2 R4 R5 first write");
        check(reg_data[7:0] == 8'hAA && reg_data[31:24] == 8'hDD, "R2 byte lanes",
              64'(reg_data), 64'hDDCCBBAA);
        idle();
        check_outs(1'b0, "R5 enable dropped");

        // R3 R9 R6: sweep addresses, window 2 disabled (mask 0)
        for (int hi = 0; hi < 2; hi++) begin
            for (int lo = 0; lo < 4096; lo++) begin
                logic [15:0] a;
                logic [31:0] d;
                a = 16'(hi * 16'h1000 + lo);
                d = {a ^ 16'h5A3C, ~a};
                send(a, d);
                check_outs(exp_hit(a), exp_hit(a) ? "R3 R9 R4 hit" : "R6 R9 miss");
                idle();
                check_outs(1'b0, "R5 single pulse");
            end
        end

        // R7: strobe aborts partial command (address phase)
        put(1'b1, 8'h05); put(1'b0, 8'h04); put(1'b0, 8'h11);
        send(16'h0407, 32'h01020304);
        check_outs(1'b1, "R7 restart after partial");
        idle();

        // R7: strobe in the sixth-byte slot
        put(1'b1, 8'h04); put(1'b0, 8'h04); put(1'b0, 8'hEE);
        put(1'b0, 8'hEE); put(1'b0, 8'hEE);
        check_outs(1'b0, "R7 partial no enable");
        send(16'h0405, 32'hCAFEF00D);
        check_outs(1'b1, "R7 restart in last slot");
        idle();

        // R8: idle bytes that look like a hit command
        for (int i = 0; i < 12; i++) begin
            put(1'b0, (i % 2 == 0) ? 8'h04 : 8'h04);
            check_outs(1'b0, "R8 idle bytes ignored");
        end

        // R10: back-to-back commands
        send(16'h0404, 32'h11111111);
        check_outs(1'b1, "R10 first of pair");
        send(16'h1233, 32'h22222222);
        check_outs(1'b1, "R10 second of pair");
        idle();
        check_outs(1'b0, "R10 after pair");

        // R6: miss after a hit holds outputs
        send(16'h0408, 32'hFFFFFFFF);
        check_outs(1'b0, "R6 miss holds");
        idle();

        // R9: disabled window base never matches
        send(16'h0800, 32'h0BADBEEF);
        check_outs(1'b0, "R9 disabled window");
        idle();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule